// File: doc/BRIEF.md
# Configuration Access Bridge

This block turns host read and write cycles into single configuration transactions for a downstream responder. A host reaches configuration space in two ways. The first is a 4 MiB memory window: one-hot select bits in the window address pick the target device, and the low address bits give the register offset. The second is the conventional pair of I/O ports: a 32-bit address latch, and a data port whose accesses reuse the latched address. For a big-endian host, halfword and word data moving through the memory window can be byte-swapped.

The host holds a request (`host_rd` or `host_wr`) with stable address, size and data until `host_done` pulses for one cycle. A read result is valid on `host_rdata` during that pulse. The control is a three-state machine:

- `ST_IDLE` waits for a claimed request.
  - Transition `IDLE->ISSUE`: a window access, or a data-port access while the latch is enabled.
  - Transition `IDLE->RESPOND`: a latch access, or a data-port access while the latch is disabled.
- `ST_ISSUE` holds `dn_valid` high until the responder raises `dn_ready`.
  - Transition `ISSUE->RESPOND`: `dn_ready` is high.
- `ST_RESPOND` pulses `host_done`.
  - Transition `RESPOND->IDLE`: always taken.

A separate interrupt router folds the level inputs of every device pin onto two outputs.

Top module: `cfg_access_bridge`

## Requirements
- R1: With `host_io`=0, an address from 0x8080_0000 to 0x80BF_FFFF and a size code of 0, 1 or 2 is claimed. Any other memory-space access (outside the window, or size code 3) gives `host_hit`=0, no downstream request and no `host_done`.
- R2: For a window access, the device number is the index (0 to 10) of the lowest set bit among address bits 11 to 21. It is 11 when none of those bits is set.
- R3: For a window access, `dn_addr`[10:0] equals host address bits [10:0], `dn_addr`[15:11] holds the device number, and `dn_addr`[23:16] is zero.
- R4: `dn_size` equals the host size code, where 0 is byte, 1 is halfword and 2 is word. `dn_we` is 1 for a write and 0 for a read.
- R5: For window accesses with `big_endian`=1, write data is byte-reversed before it reaches `dn_wdata`, and `dn_rdata` is byte-reversed before it reaches `host_rdata`. A halfword swaps bits [15:8] with [7:0] and returns zero above them; a word reverses all four bytes. Byte accesses, and all accesses with `big_endian`=0, pass the data unchanged.
- R6: An I/O word access at offset 0x0CF8 (host address bits [31:16] zero) targets the address latch. A write stores all 32 bits and a later read returns them. Reset clears the latch to zero.
- R7: I/O accesses at 0x0CFC to 0x0CFF with size code 0 to 2, while latch bit 31 is 1, issue a downstream transaction. That transaction has `dn_addr` = {latch[23:2], host address[1:0]}, the host's size code, and data that is never swapped.
- R8: A data-port access while latch bit 31 is 0 issues no downstream transaction. It completes with `host_done`, and a read returns 0xFFFF_FFFF.
- R9: `dn_valid` stays high, with `dn_addr`, `dn_size`, `dn_we` and `dn_wdata` stable, until `dn_ready`. It drops in the cycle after the handshake. Only one transaction is outstanding at a time, and `host_done` is a single-cycle pulse that never coincides with `dn_valid`.
- R10: The level input of device d, pin p is `int_lvl`[d*NUM_PIN+p]. It drives `irq_odd` (interrupt line 11) when (p+d) is odd, and `irq_even` (interrupt line 9) when (p+d) is even. Each output is the OR of its levels, registered one cycle. Reset drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Enables byte reversal for window accesses |
| host_io | input | 1 | 1 selects I/O space, 0 selects memory space |
| host_addr | input | 32 | Host address |
| host_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| host_wdata | input | 32 | Host write data, right-justified |
| host_wr | input | 1 | Write request, held until done |
| host_rd | input | 1 | Read request, held until done |
| host_hit | output | 1 | The current address is claimed |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream responder accepts or completes the request |
| dn_addr | output | 24 | Configuration address (bus, device, function, register) |
| dn_size | output | 2 | Downstream size code |
| dn_we | output | 1 | Downstream write enable |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, sampled on handshake |
| int_lvl | input | NUM_DEV*NUM_PIN | Interrupt pin levels, device-major |
| irq_even | output | 1 | Output for interrupt line 9 |
| irq_odd | output | 1 | Output for interrupt line 11 |

## Verification
The hardest case to reach from the ports is a data-port access that must be swallowed. That happens only after the latch was written with bit 31 clear, so the stimulus first writes the latch through the I/O port and then issues reads and writes to the data port. It watches that `dn_valid` never rises and that the read returns all ones. The device scan corners, namely no select bit, only the top bit, and two bits at once, are reached by choosing window addresses directly. A responder with a programmable delay holds the machine in `ST_ISSUE` for several cycles, which exercises the hold rules.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
    localparam int DATA_W = 32;
    localparam int CFG_AW = 24;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESPOND
    } brg_state_e;
endpackage

// File: rtl/cfgb_win_decode.sv
module cfgb_win_decode #(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int WIN_BITS = 22,
    parameter int OFF_BITS = 11,
    parameter int DEV_W    = 5,
    parameter int CFG_AW   = 24
) (
    input  logic [31:0]       addr,
    output logic              in_window,
    output logic [CFG_AW-1:0] cfg_addr
);
    localparam int SCAN_N = WIN_BITS - OFF_BITS;

    logic [DEV_W-1:0] dev_num;

    assign in_window = (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);

    // Lowest set select bit wins; scanning from the top lets lower bits override.
    always_comb begin
        dev_num = DEV_W'(SCAN_N);
        for (int i = SCAN_N - 1; i >= 0; i--) begin
            if (addr[OFF_BITS + i]) begin
                dev_num = DEV_W'(i);
            end
        end
    end

    always_comb begin
        cfg_addr = '0;
        cfg_addr[OFF_BITS-1:0]     = addr[OFF_BITS-1:0];
        cfg_addr[OFF_BITS +: DEV_W] = dev_num;
    end
endmodule

// File: rtl/cfgb_bswap.sv
module cfgb_bswap (
    input  logic        en,
    input  logic [1:0]  size,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    import cfgb_pkg::*;

    logic [31:0] rev_word;
    logic [31:0] rev_half;

    // Byte lanes reversed for a 4-byte word, lane k takes lane 3-k.
    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign rev_word[8*k +: 8] = din[8*(3-k) +: 8];
    end

    assign rev_half = {16'h0000, din[7:0], din[15:8]};

    always_comb begin
        dout = din;
        if (en) begin
            unique case (size)
                SZ_HALF: dout = rev_half;
                SZ_WORD: dout = rev_word;
                default: dout = din;
            endcase
        end
    end
endmodule

// File: rtl/cfgb_irq_route.sv
module cfgb_irq_route #(
    parameter int NUM_DEV = 12,
    parameter int NUM_PIN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_DEV*NUM_PIN-1:0] lvl,
    output logic                       irq_even,
    output logic                       irq_odd
);
    localparam int LVL_W = NUM_DEV * NUM_PIN;

    logic [LVL_W-1:0] odd_m;
    logic [LVL_W-1:0] even_m;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            localparam bit IS_ODD = ((d + p) % 2) == 1;
            assign odd_m[d*NUM_PIN+p]  = IS_ODD ? lvl[d*NUM_PIN+p] : 1'b0;
            assign even_m[d*NUM_PIN+p] = IS_ODD ? 1'b0 : lvl[d*NUM_PIN+p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_even <= 1'b0;
            irq_odd  <= 1'b0;
        end else begin
            irq_even <= |even_m;
            irq_odd  <= |odd_m;
        end
    end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_BITS = 22,
    parameter int          OFF_BITS = 11,
    parameter int          DEV_W    = 5,
    parameter logic [15:0] IO_LATCH = 16'h0CF8,
    parameter logic [15:0] IO_DATA  = 16'h0CFC,
    parameter int          NUM_DEV  = 12,
    parameter int          NUM_PIN  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       big_endian,
    input  logic                       host_io,
    input  logic [31:0]                host_addr,
    input  logic [1:0]                 host_size,
    input  logic [31:0]                host_wdata,
    input  logic                       host_wr,
    input  logic                       host_rd,
    output logic                       host_hit,
    output logic                       host_done,
    output logic [31:0]                host_rdata,
    output logic                       dn_valid,
    input  logic                       dn_ready,
    output logic [23:0]                dn_addr,
    output logic [1:0]                 dn_size,
    output logic                       dn_we,
    output logic [31:0]                dn_wdata,
    input  logic [31:0]                dn_rdata,
    input  logic [NUM_DEV*NUM_PIN-1:0] int_lvl,
    output logic                       irq_even,
    output logic                       irq_odd
);
    import cfgb_pkg::*;

    localparam int LATCH_EN_BIT = 31;

    brg_state_e state_q, state_d;

    logic [31:0]       latch_q;
    logic [CFG_AW-1:0] addr_q;
    logic [1:0]        size_q;
    logic              we_q;
    logic [31:0]       wdata_q;
    logic              swap_q;
    logic [31:0]       rdata_q;

    logic              win_in;
    logic [CFG_AW-1:0] win_cfg;
    logic              size_ok;
    logic              io_low;
    logic              win_sel;
    logic              latch_sel;
    logic              port_sel;
    logic              req;
    logic              take;
    logic              port_blocked;
    logic [CFG_AW-1:0] fwd_addr;
    logic [31:0]       wr_conv;
    logic [31:0]       rd_conv;

    // ---------------- address decode ----------------
    cfgb_win_decode #(
        .WIN_BASE (WIN_BASE),
        .WIN_BITS (WIN_BITS),
        .OFF_BITS (OFF_BITS),
        .DEV_W    (DEV_W),
        .CFG_AW   (CFG_AW)
    ) u_win (
        .addr      (host_addr),
        .in_window (win_in),
        .cfg_addr  (win_cfg)
    );

    assign size_ok   = (host_size != 2'd3);
    assign io_low    = (host_addr[31:16] == 16'h0000);
    assign win_sel   = !host_io && win_in && size_ok;
    assign latch_sel = host_io && io_low && (host_addr[15:0] == IO_LATCH)
                       && (host_size == SZ_WORD);
    assign port_sel  = host_io && io_low && (host_addr[15:2] == IO_DATA[15:2])
                       && size_ok;
    assign host_hit  = win_sel || latch_sel || port_sel;

    assign req          = host_rd || host_wr;
    assign take         = (state_q == ST_IDLE) && req && host_hit;
    assign port_blocked = port_sel && !latch_q[LATCH_EN_BIT];
    assign fwd_addr     = win_sel ? win_cfg : {latch_q[CFG_AW-1:2], host_addr[1:0]};

    // ---------------- data conversion ----------------
    cfgb_bswap u_wswap (
        .en   (big_endian && win_sel),
        .size (host_size),
        .din  (host_wdata),
        .dout (wr_conv)
    );

    cfgb_bswap u_rswap (
        .en   (swap_q),
        .size (size_q),
        .din  (dn_rdata),
        .dout (rd_conv)
    );

    // ---------------- state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (latch_sel || port_blocked) begin
                        state_d = ST_RESPOND;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (dn_ready) begin
                    state_d = ST_RESPOND;
                end
            end
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dn_valid  = (state_q == ST_ISSUE);
        host_done = (state_q == ST_RESPOND);
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            addr_q  <= '0;
            size_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            swap_q  <= 1'b0;
            rdata_q <= '0;
        end else if (take) begin
            if (latch_sel) begin
                rdata_q <= latch_q;
                if (host_wr) begin
                    latch_q <= host_wdata;
                end
            end else if (port_blocked) begin
                rdata_q <= '1;
            end else begin
                addr_q  <= fwd_addr;
                size_q  <= host_size;
                we_q    <= host_wr;
                wdata_q <= wr_conv;
                swap_q  <= big_endian && win_sel;
            end
        end else if ((state_q == ST_ISSUE) && dn_ready) begin
            rdata_q <= rd_conv;
        end
    end

    assign dn_addr    = addr_q;
    assign dn_size    = size_q;
    assign dn_we      = we_q;
    assign dn_wdata   = wdata_q;
    assign host_rdata = rdata_q;

    // ---------------- interrupt routing ----------------
    cfgb_irq_route #(
        .NUM_DEV (NUM_DEV),
        .NUM_PIN (NUM_PIN)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (int_lvl),
        .irq_even (irq_even),
        .irq_odd  (irq_odd)
    );
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
    parameter int LVL_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_rd,
    input logic             host_wr,
    input logic             host_hit,
    input logic             host_done,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic [23:0]      dn_addr,
    input logic [1:0]       dn_size,
    input logic             dn_we,
    input logic [31:0]      dn_wdata,
    input logic [LVL_W-1:0] int_lvl,
    input logic             irq_even,
    input logic             irq_odd
);
    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_size)
                                     && $stable(dn_we) && $stable(dn_wdata)));

    a_r9_drop_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) |=> !dn_valid);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    a_r9_done_excl_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_done && dn_valid));

    a_r1_unclaimed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && !host_hit && !dn_valid && !host_done)
            |=> (!dn_valid && !host_done));

    a_r10_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (int_lvl == '0) |=> (!irq_even && !irq_odd));
endmodule

bind cfg_access_bridge cfgb_checker #(.LVL_W(NUM_DEV*NUM_PIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_hit  (host_hit),
    .host_done (host_done),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_addr   (dn_addr),
    .dn_size   (dn_size),
    .dn_we     (dn_we),
    .dn_wdata  (dn_wdata),
    .int_lvl   (int_lvl),
    .irq_even  (irq_even),
    .irq_odd   (irq_odd)
);

// File: tb/test_cfg_access_bridge.sv
module test_cfg_access_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 12;
    localparam int NPIN = 4;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        host_io = 1'b0;
    logic [31:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_hit;
    logic        host_done;
    logic [31:0] host_rdata;
    logic        dn_valid;
    logic        dn_ready = 1'b0;
    logic [23:0] dn_addr;
    logic [1:0]  dn_size;
    logic        dn_we;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata = '0;
    logic [NDEV*NPIN-1:0] int_lvl = '0;
    logic        irq_even;
    logic        irq_odd;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // responder model state
    int          rsp_delay = 0;
    int          wait_cnt = 0;
    bit          dn_seen = 0;
    logic [23:0] cap_addr;
    logic [1:0]  cap_size;
    logic        cap_we;
    logic [31:0] cap_wdata;

    // results of the last host access
    bit          got_done;
    bit          got_hit;
    logic [31:0] got_rdata;
    int          done_pulses;

    cfg_access_bridge #(.NUM_DEV(NDEV), .NUM_PIN(NPIN)) i_cfg_access_bridge (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .host_io(host_io),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_hit(host_hit),
        .host_done(host_done), .host_rdata(host_rdata), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_size(dn_size), .dn_we(dn_we),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .int_lvl(int_lvl),
        .irq_even(irq_even), .irq_odd(irq_odd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    always @(negedge clk) begin
        dn_ready = 1'b0;
        if (dn_valid) begin
            if (wait_cnt >= rsp_delay) begin
                dn_ready  = 1'b1;
                dn_seen   = 1;
                cap_addr  = dn_addr;
                cap_size  = dn_size;
                cap_we    = dn_we;
                cap_wdata = dn_wdata;
                wait_cnt  = 0;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic io, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic wr);
        @(negedge clk);
        host_io = io; host_addr = a; host_size = sz; host_wdata = wd;
        host_wr = wr; host_rd = !wr;
        dn_seen = 0; got_done = 0; got_hit = 0; done_pulses = 0; got_rdata = 'x;
        for (int i = 0; i < 30 && !got_done; i++) begin
            @(negedge clk);
            if (i == 0) got_hit = host_hit;
            if (host_done) begin
                got_done = 1; got_rdata = host_rdata; done_pulses++;
            end
        end
        host_wr = 0; host_rd = 0;
        // make sure no second pulse follows
        @(negedge clk);
        if (host_done) done_pulses++;
    endtask

    task automatic t_reset;
        chk("R10 reset irq_even", {31'b0, irq_even}, 32'd0);
        chk("R10 reset irq_odd", {31'b0, irq_odd}, 32'd0);
        chk("R9 reset dn_valid", {31'b0, dn_valid}, 32'd0);
        access(1, 32'h0CF8, 2'd2, 0, 0);
        chk("R6 latch reset value", got_rdata, 32'h0);
    endtask

    task automatic win_read(input logic [31:0] a, input logic [23:0] exp_addr, input string tag);
        dn_rdata = 32'h0000_00AB;
        access(0, a, 2'd0, 0, 0);
        chk({tag, " done"}, {31'b0, got_done}, 32'd1);
        chk({tag, " dn_addr"}, {8'h0, cap_addr}, {8'h0, exp_addr});
    endtask

    task automatic t_window_scan;
        big_endian = 0;
        win_read(32'h8080_2004, 24'h001004, "R2 R3 dev2");
        win_read(32'h8080_0010, 24'h005810, "R2 R3 none set dev11");
        win_read(32'h8082_1000, 24'h000800, "R2 two bits dev1");
        win_read(32'h80A0_07FF, 24'h0057FF, "R2 R3 top bit dev10");
        chk("R4 byte read size", {30'b0, cap_size}, 32'd0);
        chk("R4 read we", {31'b0, cap_we}, 32'd0);
        chk("R5 byte read unswapped", got_rdata, 32'h0000_00AB);
    endtask

    task automatic t_endian;
        big_endian = 1;
        access(0, 32'h8080_0800, 2'd2, 32'h1122_3344, 1);
        chk("R5 word write swapped", cap_wdata, 32'h4433_2211);
        chk("R4 word write size", {30'b0, cap_size}, 32'd2);
        chk("R4 write we", {31'b0, cap_we}, 32'd1);
        access(0, 32'h8080_0802, 2'd1, 32'h0000_AABB, 1);
        chk("R5 half write swapped", cap_wdata, 32'h0000_BBAA);
        chk("R4 half size", {30'b0, cap_size}, 32'd1);
        access(0, 32'h8080_0803, 2'd0, 32'h0000_005A, 1);
        chk("R5 byte write unswapped", cap_wdata, 32'h0000_005A);
        dn_rdata = 32'h0102_0304;
        access(0, 32'h8080_0800, 2'd2, 0, 0);
        chk("R5 word read swapped", got_rdata, 32'h0403_0201);
        dn_rdata = 32'h0000_1234;
        access(0, 32'h8080_0800, 2'd1, 0, 0);
        chk("R5 half read swapped", got_rdata, 32'h0000_3412);
        big_endian = 0;
        access(0, 32'h8080_0800, 2'd2, 32'h1122_3344, 1);
        chk("R5 little-endian write unswapped", cap_wdata, 32'h1122_3344);
    endtask

    task automatic unclaimed(input logic io, input logic [31:0] a, input logic [1:0] sz, input string tag);
        access(io, a, sz, 0, 0);
        chk({tag, " hit"}, {31'b0, got_hit}, 32'd0);
        chk({tag, " done"}, {31'b0, got_done}, 32'd0);
        chk({tag, " downstream"}, {31'b0, dn_seen}, 32'd0);
    endtask

    task automatic t_outside;
        unclaimed(0, 32'h80C0_0000, 2'd2, "R1 above window");
        unclaimed(0, 32'h807F_FFFC, 2'd2, "R1 below window");
        unclaimed(0, 32'h8080_0000, 2'd3, "R1 size code 3");
        unclaimed(1, 32'h0000_0CF8, 2'd0, "R6 latch byte size");
    endtask

    task automatic t_latch_and_port;
        access(1, 32'h0CF8, 2'd2, 32'h8012_3A10, 1);
        chk("R6 latch write no downstream", {31'b0, dn_seen}, 32'd0);
        access(1, 32'h0CF8, 2'd2, 0, 0);
        chk("R6 latch readback", got_rdata, 32'h8012_3A10);
        dn_rdata = 32'h0000_00C3;
        access(1, 32'h0CFE, 2'd0, 0, 0);
        chk("R7 port byte addr", {8'h0, cap_addr}, 32'h0012_3A12);
        chk("R7 port byte data", got_rdata, 32'h0000_00C3);
        big_endian = 1;
        access(1, 32'h0CFC, 2'd2, 32'h1122_3344, 1);
        chk("R7 port word addr", {8'h0, cap_addr}, 32'h0012_3A10);
        chk("R7 port word never swapped", cap_wdata, 32'h1122_3344);
        chk("R7 port word size", {30'b0, cap_size}, 32'd2);
        big_endian = 0;
    endtask

    task automatic t_port_disabled;
        access(1, 32'h0CF8, 2'd2, 32'h0012_3A10, 1);
        dn_rdata = 32'h0000_0000;
        access(1, 32'h0CFC, 2'd2, 0, 0);
        chk("R8 disabled read all ones", got_rdata, 32'hFFFF_FFFF);
        chk("R8 disabled read done", {31'b0, got_done}, 32'd1);
        chk("R8 disabled read no downstream", {31'b0, dn_seen}, 32'd0);
        access(1, 32'h0CFD, 2'd0, 32'h77, 1);
        chk("R8 disabled write done", {31'b0, got_done}, 32'd1);
        chk("R8 disabled write no downstream", {31'b0, dn_seen}, 32'd0);
    endtask

    task automatic t_handshake;
        rsp_delay = 5;
        dn_rdata = 32'h0000_00E1;
        access(0, 32'h8080_1000, 2'd0, 0, 0);
        chk("R9 slow responder done", {31'b0, got_done}, 32'd1);
        chk("R9 single done pulse", done_pulses, 32'd1);
        chk("R9 data after wait", got_rdata, 32'h0000_00E1);
        chk("R2 R3 dev1 slow", {8'h0, cap_addr}, 32'h0000_0800);
        rsp_delay = 0;
    endtask

    task automatic irq_case(input int d, input int p, input logic e, input logic o, input string tag);
        @(negedge clk);
        int_lvl = '0;
        if (d >= 0) int_lvl[d*NPIN+p] = 1'b1;
        @(negedge clk);
        chk({tag, " irq_even"}, {31'b0, irq_even}, {31'b0, e});
        chk({tag, " irq_odd"}, {31'b0, irq_odd}, {31'b0, o});
    endtask

    task automatic t_irq;
        irq_case(3, 0, 1'b0, 1'b1, "R10 dev3 pin0 odd");
        irq_case(3, 1, 1'b1, 1'b0, "R10 dev3 pin1 even");
        irq_case(0, 2, 1'b1, 1'b0, "R10 dev0 pin2 even");
        irq_case(11, 2, 1'b0, 1'b1, "R10 dev11 pin2 odd");
        irq_case(-1, 0, 1'b0, 1'b0, "R10 no levels");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window_scan();
        t_endian();
        t_outside();
        t_latch_and_port();
        t_port_disabled();
        t_handshake();
        t_irq();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule